// File: doc/BRIEF.md
# Debug Monitor Mode Entry Controller

This block decides, once per power-on, whether the chip starts in its serial debug monitor mode. On the first clock after the active-low power-on reset is released it samples the two reset-vector bytes, a high-voltage detect flag for the interrupt pin, the interrupt pin's logic level and a strap pin. It then holds that decision until the next power-on reset. Two entry paths exist. The high-voltage path is used when the vector is programmed. The blank-vector path is used when both vector bytes are erased. The blank-vector path adds a fixed internal reset pulse before monitor mode is reported.

The block also drives the watchdog-disable signal, a PLL request for low-frequency crystal start-up, and a bus clock enable. The bus clock enable comes from a small programmable divider that runs at the latched ratio.

The sequencer is built around four named states:
- `ST_POR` waits for power-on reset to be released.
- `ST_EXTRA_RST` holds the internal reset pulse.
- `ST_MONITOR` is the active monitor mode.
- `ST_NORMAL` means the chip did not enter monitor mode.

The transitions are as follows:
- `ST_POR` goes to `ST_EXTRA_RST` on the first clock after release if the vector is blank.
- `ST_POR` goes to `ST_MONITOR` on that clock if the vector is programmed and the high-voltage flag is set.
- `ST_POR` goes to `ST_NORMAL` on that clock in every other case.
- `ST_EXTRA_RST` goes to `ST_MONITOR` when its cycle counter reaches the last count.
- Power-on reset returns every state to `ST_POR` asynchronously.

Top module: `monitor_entry_ctrl`

## Requirements
- R1: The vector counts as blank only when both `vec_hi` and `vec_lo` are all ones (0xFF). If only one byte is 0xFF, the vector is programmed.
- R2: With a programmed vector, monitor mode is entered only if `irq_hv` is 1 on the first clock after `por_n` rises. Otherwise `mon_active`, `pll_req`, `wdog_dis` and `int_rst` stay 0 and `bus_div4` stays 1.
- R3: On high-voltage entry, `mon_active` is 1 from the first clock after release. `bus_div4` equals the strap level: 0 means divide by 2, 1 means divide by 4. `pll_req` is 0.
- R4: On blank entry with `irq_lvl` = 1, the strap is ignored, `bus_div4` = 1 and `pll_req` = 0. Blank entry takes priority over `irq_hv`.
- R5: On blank entry with `irq_lvl` = 0, `pll_req` = 1 and `bus_div4` = 1.
- R6: On blank entry, `int_rst` is 1 for exactly 16 clocks, starting with the first clock after release. `mon_active` is 0 during the pulse and becomes 1 on the clock after the pulse ends.
- R7: After the first clock following release, changes on `vec_hi`, `vec_lo`, `irq_lvl`, `strap_pin` and `irq_hv` do not change `mon_active`, `bus_div4` or `pll_req` until the next power-on reset.
- R8: `bus_ce` is a one-cycle pulse every 2 clocks when `bus_div4` = 0 and every 4 clocks when `bus_div4` = 1. Outside monitor mode the ratio is 4.
- R9: After blank entry, `wdog_dis` is 1 whatever `irq_hv` and `rst_hv` do.
- R10: After high-voltage entry, `wdog_dis` equals `irq_hv` OR `rst_hv` in every cycle. High voltage may therefore move from the interrupt pin to the reset pin without the watchdog being re-enabled.
- R11: While `por_n` = 0, `mon_active`, `pll_req`, `wdog_dis` and `int_rst` are 0 and `bus_div4` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| irq_hv | input | 1 | High voltage detected on the interrupt pin |
| irq_lvl | input | 1 | Logic level of the interrupt pin |
| strap_pin | input | 1 | Divide strap, 0 = divide by 2, 1 = divide by 4 (high-voltage entry only) |
| rst_hv | input | 1 | High voltage detected on the reset pin |
| vec_hi | input | 8 | Reset vector upper byte |
| vec_lo | input | 8 | Reset vector lower byte |
| mon_active | output | 1 | Monitor mode active |
| bus_div4 | output | 1 | Selected ratio, 1 = divide by 4, 0 = divide by 2 |
| bus_ce | output | 1 | Bus clock enable pulse |
| pll_req | output | 1 | Request to start the PLL from a low-frequency crystal |
| wdog_dis | output | 1 | Watchdog disable |
| int_rst | output | 1 | Extra internal reset pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit vector byte width and a 16-cycle extra reset. With these values the bench can count every clock of the extra reset pulse and see the exact cycle in which monitor mode appears. The exact all-ones compare is exercised with vectors that differ from 0xFF in a single bit. The divider ratios 2 and 4 are both reached, so the bench can count enable pulses against each ratio.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;

    typedef enum logic [1:0] {
        ST_POR,
        ST_EXTRA_RST,
        ST_MONITOR,
        ST_NORMAL
    } mon_state_e;

    typedef enum logic [1:0] {
        ENT_NONE,
        ENT_HV,
        ENT_BLANK
    } entry_e;

    typedef struct packed {
        entry_e kind;
        logic   div4;
        logic   pll;
    } entry_dec_t;

endpackage

// File: rtl/mon_strap_decode.sv
module mon_strap_decode
    import mon_entry_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0] vec_hi,
    input  logic [VEC_W-1:0] vec_lo,
    input  logic             irq_hv,
    input  logic             irq_lvl,
    input  logic             strap_pin,
    output entry_dec_t       dec
);

    logic blank;

    // Blank only when every bit of both bytes reads as one.
    assign blank = (&vec_hi) & (&vec_lo);

    always_comb begin
        if (blank) begin
            dec.kind = ENT_BLANK;
            dec.div4 = 1'b1;
            dec.pll  = ~irq_lvl;
        end else if (irq_hv) begin
            dec.kind = ENT_HV;
            dec.div4 = strap_pin;
            dec.pll  = 1'b0;
        end else begin
            dec.kind = ENT_NONE;
            dec.div4 = 1'b1;
            dec.pll  = 1'b0;
        end
    end

    always_comb begin
        AST_BLANK_NO_STRAP: assert (!blank || dec.div4) else $error("blank entry must use ratio 4"); // R4
    end

endmodule

// File: rtl/mon_seq_fsm.sv
module mon_seq_fsm
    import mon_entry_pkg::*;
#(
    parameter int RST_CYC = 16
) (
    input  logic       clk,
    input  logic       por_n,
    input  entry_dec_t dec_in,
    output entry_e     kind_q,
    output logic       div4_q,
    output logic       pll_q,
    output logic       int_rst,
    output logic       mon_active
);

    localparam int CNT_W = (RST_CYC > 2) ? $clog2(RST_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYC - 1);

    mon_state_e      st_q, st_d;
    logic [CNT_W-1:0] cnt_q;

    // State register and latched decision
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q   <= ST_POR;
            cnt_q  <= '0;
            kind_q <= ENT_NONE;
            div4_q <= 1'b1;
            pll_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_POR) begin
                kind_q <= dec_in.kind;
                div4_q <= dec_in.div4;
                pll_q  <= dec_in.pll;
                cnt_q  <= '0;
            end else if (st_q == ST_EXTRA_RST) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_POR: begin
                unique case (dec_in.kind)
                    ENT_BLANK: st_d = ST_EXTRA_RST;
                    ENT_HV:    st_d = ST_MONITOR;
                    default:   st_d = ST_NORMAL;
                endcase
            end
            ST_EXTRA_RST: if (cnt_q == LAST) st_d = ST_MONITOR;
            ST_MONITOR:   st_d = ST_MONITOR;
            ST_NORMAL:    st_d = ST_NORMAL;
            default:      st_d = ST_POR;
        endcase
    end

    // Outputs
    always_comb begin
        int_rst    = 1'b0;
        mon_active = 1'b0;
        unique case (st_q)
            ST_EXTRA_RST: int_rst    = 1'b1;
            ST_MONITOR:   mon_active = 1'b1;
            default: ;
        endcase
    end

    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (int_rst && cnt_q != LAST) |=> int_rst); // R6
    AST_PULSE_END: assert property (@(posedge clk) disable iff (!por_n)
        (int_rst && cnt_q == LAST) |=> (!int_rst && mon_active)); // R6
    AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!por_n)
        (st_q != ST_POR) |=> ($stable(div4_q) && $stable(pll_q) && $stable(kind_q))); // R7
    AST_MON_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        mon_active |=> mon_active); // R7

endmodule

// File: rtl/bus_clk_div.sv
module bus_clk_div #(
    parameter int LO_DIV = 2,
    parameter int HI_DIV = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic sel_hi,
    output logic ce
);

    localparam int CNT_W = (HI_DIV > 2) ? $clog2(HI_DIV) : 1;
    localparam logic [CNT_W-1:0] LO_LAST = CNT_W'(LO_DIV - 1);
    localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(HI_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    assign last = sel_hi ? HI_LAST : LO_LAST;
    assign ce   = (cnt_q == last);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)              cnt_q <= '0;
        else if (cnt_q >= last)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    AST_CE_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
        ce |=> !ce); // R8
    AST_CE_RESTART: assert property (@(posedge clk) disable iff (!por_n)
        ce |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/monitor_entry_ctrl.sv
module monitor_entry_ctrl
    import mon_entry_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int RST_CYC = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             irq_hv,
    input  logic             irq_lvl,
    input  logic             strap_pin,
    input  logic             rst_hv,
    input  logic [VEC_W-1:0] vec_hi,
    input  logic [VEC_W-1:0] vec_lo,
    output logic             mon_active,
    output logic             bus_div4,
    output logic             bus_ce,
    output logic             pll_req,
    output logic             wdog_dis,
    output logic             int_rst
);

    entry_dec_t dec;
    entry_e     kind_q;
    logic       div4_q;
    logic       pll_q;

    mon_strap_decode #(.VEC_W(VEC_W)) u_dec (
        .vec_hi    (vec_hi),
        .vec_lo    (vec_lo),
        .irq_hv    (irq_hv),
        .irq_lvl   (irq_lvl),
        .strap_pin (strap_pin),
        .dec       (dec)
    );

    mon_seq_fsm #(.RST_CYC(RST_CYC)) u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .dec_in     (dec),
        .kind_q     (kind_q),
        .div4_q     (div4_q),
        .pll_q      (pll_q),
        .int_rst    (int_rst),
        .mon_active (mon_active)
    );

    bus_clk_div #(.LO_DIV(2), .HI_DIV(4)) u_div (
        .clk    (clk),
        .por_n  (por_n),
        .sel_hi (div4_q),
        .ce     (bus_ce)
    );

    assign bus_div4 = div4_q;
    assign pll_req  = pll_q;

    // Watchdog hold: permanent for blank entry, live pin check for high-voltage entry
    always_comb begin
        unique case (kind_q)
            ENT_BLANK: wdog_dis = 1'b1;
            ENT_HV:    wdog_dis = irq_hv | rst_hv;
            default:   wdog_dis = 1'b0;
        endcase
    end

    AST_NO_ENTRY_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        (kind_q == ENT_NONE) |-> (!mon_active && !pll_req && !wdog_dis && !int_rst)); // R2
    AST_PULSE_NOT_MON: assert property (@(posedge clk) disable iff (!por_n)
        int_rst |-> (!mon_active && wdog_dis)); // R6
    AST_PLL_BLANK_ONLY: assert property (@(posedge clk) disable iff (!por_n)
        pll_req |-> (bus_div4 && (int_rst || mon_active))); // R5

endmodule

// File: tb/monitor_entry_ctrl_tb.sv
module monitor_entry_ctrl_tb;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       irq_hv = 1'b0, irq_lvl = 1'b0, strap_pin = 1'b0, rst_hv = 1'b0;
    logic [7:0] vec_hi = 8'h00, vec_lo = 8'h00;
    logic       mon_active, bus_div4, bus_ce, pll_req, wdog_dis, int_rst;

    always #5 clk = ~clk;

    monitor_entry_ctrl u_dut (
        .clk(clk), .por_n(por_n), .irq_hv(irq_hv), .irq_lvl(irq_lvl),
        .strap_pin(strap_pin), .rst_hv(rst_hv), .vec_hi(vec_hi), .vec_lo(vec_lo),
        .mon_active(mon_active), .bus_div4(bus_div4), .bus_ce(bus_ce),
        .pll_req(pll_req), .wdog_dis(wdog_dis), .int_rst(int_rst)
    );

    typedef struct {
        logic [4:0] v;   // {mon, div4, pll, wd, irst}
        string      req;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    task automatic push(input bit m, input bit d, input bit p, input bit w,
                        input bit i, input string req);
        exp_t e;
        e.v   = {m, d, p, w, i};
        e.req = req;
        q.push_back(e);
    endtask

    // Monitor: pop one expectation per clock, sampled after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                logic [4:0] act;
                e   = q.pop_front();
                act = {mon_active, bus_div4, pll_req, wdog_dis, int_rst};
                total++;
                if (act !== e.v) begin
                    bad++;
                    $display("FAIL %s: {mon,div4,pll,wd,irst} actual=%b expected=%b",
                             e.req, act, e.v);
                end
            end
        end
    end

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
    endtask

    // Power-on with given straps; expectations for reset state and entry
    task automatic power_on(input bit hv, input bit lvl, input bit strap, input bit rhv,
                            input logic [7:0] hi, input logic [7:0] lo);
        bit blank;
        @(negedge clk);
        por_n = 1'b0; irq_hv = hv; irq_lvl = lvl; strap_pin = strap; rst_hv = rhv;
        vec_hi = hi; vec_lo = lo;
        push(0, 1, 0, 0, 0, "R11 reset state");
        drain();
        @(negedge clk);
        por_n = 1'b1;
        blank = (hi == 8'hFF) && (lo == 8'hFF);
        if (blank) begin
            for (int k = 0; k < 16; k++)
                push(0, 1, ~lvl, 1, 1, "R6 extra reset pulse");
            push(1, 1, ~lvl, 1, 0, "R6 monitor after pulse");
        end else if (hv) begin
            push(1, strap, 0, 1, 0, "R3 high-voltage entry");
        end else begin
            push(0, 1, 0, 0, 0, "R2 normal start");
        end
        drain();
    endtask

    task automatic check_ce(input int period, input string req);
        int  pulses = 0;
        bit  prev = 0;
        bit  consec = 0;
        repeat (4) @(posedge clk);
        for (int k = 0; k < 12; k++) begin
            @(posedge clk);
            #2;
            if (bus_ce && prev) consec = 1;
            pulses += bus_ce;
            prev = bus_ce;
        end
        total++;
        if (pulses != 12 / period || consec) begin
            bad++;
            $display("FAIL %s: ce pulses actual=%0d expected=%0d consecutive=%0d",
                     req, pulses, 12 / period, consec);
        end
        @(negedge clk);
    endtask

    task automatic step(input bit m, input bit d, input bit p, input bit w,
                        input string req);
        push(m, d, p, w, 0, req);
        drain();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);

        // R2: programmed vector, no high voltage
        power_on(0, 1, 1, 0, 8'h12, 8'h34);
        check_ce(4, "R8 normal ratio 4");

        // R1: one byte erased is not blank
        power_on(0, 1, 0, 0, 8'hFF, 8'hFE);
        power_on(0, 0, 0, 0, 8'h7F, 8'hFF);

        // R3/R10/R7: high-voltage entry, strap low
        power_on(1, 1, 0, 0, 8'h00, 8'h80);
        check_ce(2, "R8 ratio 2");
        @(negedge clk);
        rst_hv = 1'b1;                     // R10 hand-over to reset pin
        step(1, 0, 0, 1, "R10 both pins high");
        irq_hv = 1'b0;
        step(1, 0, 0, 1, "R10 reset pin only");
        rst_hv = 1'b0;
        step(1, 0, 0, 0, "R10 no high voltage");
        strap_pin = 1'b1; vec_hi = 8'hFF; vec_lo = 8'hFF; irq_lvl = 1'b0;
        step(1, 0, 0, 0, "R7 straps changed later");
        irq_hv = 1'b1;
        step(1, 0, 0, 1, "R10 interrupt pin again");

        // R3: strap high
        power_on(1, 1, 1, 0, 8'h00, 8'h00);
        check_ce(4, "R8 ratio 4 by strap");

        // R4: blank, irq level high, strap low, even with irq_hv set
        power_on(1, 1, 0, 0, 8'hFF, 8'hFF);
        check_ce(4, "R4 blank ratio 4");
        irq_hv = 1'b0; rst_hv = 1'b0;
        step(1, 1, 0, 1, "R9 no high voltage");
        rst_hv = 1'b1;
        step(1, 1, 0, 1, "R9 reset pin high");
        irq_lvl = 1'b0; strap_pin = 1'b1; vec_lo = 8'h00;
        step(1, 1, 0, 1, "R7 blank latch kept");

        // R5: blank, irq level low
        power_on(0, 0, 0, 0, 8'hFF, 8'hFF);
        irq_lvl = 1'b1;
        step(1, 1, 1, 1, "R5 pll request kept");

        drain();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule